// File: doc/BRIEF.md
# Scan List Sequencer

This block keeps a short list of conversion entries for an analog front end. Each entry pairs an input channel with a gain code. Software fills the list by writing a slot number to an index port and then writing the entry word to an entry port. The entry word goes into the slot that the index currently points at. During an acquisition, each conversion trigger hands the entry under the index to the mux and gain stage. With scanning enabled, the index then moves to the next slot. After an entry that carries the end-of-list flag, the index goes back to slot 0. The block does not drive the analog mux or set the gain itself. It only supplies the selection.

When scanning is disabled, the index stays where it is. Every conversion then reuses the one entry it points at. The block also produces two one-cycle pulses that travel with the selection. One pulse marks that the first slot of a scan was consumed. The other marks that the end of the list was reached. The index port has two uses: it selects the slot to fill, and writing 0 to it rewinds the sequence before a new run.

The entry port, the index port and the trigger are plain single-cycle strobes. Every strobe is accepted in the cycle it is high. No back-pressure exists. The selection output is a one-cycle valid pulse, and the receiving stage must take it in that cycle.

Top module: `scan_list_seq`

## Requirements
- R1: After reset the list holds all zeros, the index is 0, and sel_valid, scan_start, scan_end, sel_chan and sel_gain are all 0.
- R2: A high idx_wr loads idx_data into the index. A later ent_wr stores its word into the slot under the index, and the index does not move.
- R3: An entry word has four fields. Bits 3:0 are the channel. Bit 4 is the end-of-list flag. Bits 7:6 are the gain code. Bit 5 and bits above 7 are ignored.
- R4: conv_trig high at a clock edge makes sel_valid high for the following cycle. In that cycle sel_chan and sel_gain carry the entry that was under the index at that edge.
- R5: When scan_en is high, each trigger moves the index forward by one. If the consumed entry has the end-of-list flag set, the index returns to 0 instead.
- R6: In scan mode, scan_end is high in the same cycle as sel_valid exactly when the consumed entry has the end-of-list flag.
- R7: If no entry carries the end-of-list flag, the index wraps from slot 15 to slot 0, and scan_end stays low.
- R8: When scan_en is low, the index holds, every trigger presents the same entry, and scan_start and scan_end stay low.
- R9: scan_start is high together with sel_valid when the consumed entry came from slot 0 while scan_en and multi_en were both high. Otherwise scan_start is low.
- R10: If idx_wr and conv_trig are both high at the same edge, the presented entry comes from the old index, and the index takes idx_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Strobe that loads the index |
| idx_data | input | 4 | New index value |
| ent_wr | input | 1 | Strobe that stores an entry word |
| ent_data | input | 16 | Entry word |
| scan_en | input | 1 | Enables stepping through the list |
| multi_en | input | 1 | Multi-channel qualifier that gates scan_start |
| conv_trig | input | 1 | Conversion trigger |
| sel_valid | output | 1 | Selection valid for one cycle |
| sel_chan | output | 4 | Selected channel |
| sel_gain | output | 2 | Selected gain code |
| scan_start | output | 1 | Slot 0 of a scan was consumed |
| scan_end | output | 1 | End-of-list entry was consumed |

## Verification
Three patterns exercise the main stepping function.

- **Three-entry list:** the end-of-list flag sits on the third entry, and the list is walked across more than two laps. This separates a correct wrap on the flag from a wrap at full depth. It also confirms that the scan_start and scan_end pulses line up with the right slots.
- **Sixteen entries, no flag:** this shows the wrap from slot 15 and that scan_end stays silent.
- **Scan disabled:** repeated triggers must present one fixed entry with neither pulse.

Directed cases cover two further points. One is a trigger in the same cycle as an index write. The other is an entry word with its unused bits set, which must not change the channel or the gain.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;
  localparam int CHAN_W   = 4;
  localparam int GAIN_W   = 2;
  localparam int LAST_BIT = 4;
  localparam int GAIN_LSB = 6;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic              last;
    logic [CHAN_W-1:0] chan;
  } scan_entry_t;
endpackage

// File: rtl/scanseq_list.sv
module scanseq_list
  import scanseq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  scan_entry_t      wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output scan_entry_t      rd_entry
);
  scan_entry_t slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[i] <= '0;
      else if (wr_en && wr_idx == IDX_W'(i))
        slot_q[i] <= wr_entry;
    end
  end

  assign rd_entry = slot_q[rd_idx];

  // R2: a stored word is read back from its slot on the next cycle
  assert_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_idx != $past(wr_idx)) || (rd_entry == $past(wr_entry)));
endmodule

// File: rtl/scanseq_ptr.sv
module scanseq_ptr #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DEPTH - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  input  logic             last,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (load)
      ptr <= load_val;
    else if (step)
      ptr <= (last || ptr == TOP_IDX) ? '0 : ptr + 1'b1;
  end

  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ptr == $past(load_val));
  assert_rewind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && last) |=> ptr == '0);
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && ptr == TOP_IDX) |=> ptr == '0);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(ptr));
endmodule

// File: rtl/scanseq_out.sv
module scanseq_out
  import scanseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  scan_entry_t       entry,
  input  logic              scan_en,
  input  logic              multi_en,
  input  logic              at_first,
  output logic              sel_valid,
  output logic [CHAN_W-1:0] sel_chan,
  output logic [GAIN_W-1:0] sel_gain,
  output logic              scan_start,
  output logic              scan_end
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_valid  <= 1'b0;
      sel_chan   <= '0;
      sel_gain   <= '0;
      scan_start <= 1'b0;
      scan_end   <= 1'b0;
    end else begin
      sel_valid  <= trig;
      scan_end   <= trig && scan_en && entry.last;
      scan_start <= trig && scan_en && multi_en && at_first;
      if (trig) begin
        sel_chan <= entry.chan;
        sel_gain <= entry.gain;
      end
    end
  end

  assert_end_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_end |-> sel_valid);
  assert_start_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |-> sel_valid);
  assert_quiet_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !scan_en) |=> (!scan_end && !scan_start));
  assert_sel_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> ($stable(sel_chan) && $stable(sel_gain)));
endmodule

// File: rtl/scan_list_seq.sv
module scan_list_seq
  import scanseq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [IDX_W-1:0]  idx_data,
  input  logic              ent_wr,
  input  logic [WORD_W-1:0] ent_data,
  input  logic              scan_en,
  input  logic              multi_en,
  input  logic              conv_trig,
  output logic              sel_valid,
  output logic [CHAN_W-1:0] sel_chan,
  output logic [GAIN_W-1:0] sel_gain,
  output logic              scan_start,
  output logic              scan_end
);
  scan_entry_t      wr_entry;
  scan_entry_t      cur_entry;
  logic [IDX_W-1:0] idx_q;

  assign wr_entry.chan = ent_data[CHAN_W-1:0];
  assign wr_entry.last = ent_data[LAST_BIT];
  assign wr_entry.gain = ent_data[GAIN_LSB +: GAIN_W];

  scanseq_list #(.DEPTH(DEPTH)) u_list (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ent_wr),
    .wr_idx   (idx_q),
    .wr_entry (wr_entry),
    .rd_idx   (idx_q),
    .rd_entry (cur_entry)
  );

  scanseq_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (idx_wr),
    .load_val (idx_data),
    .step     (conv_trig && scan_en),
    .last     (cur_entry.last),
    .ptr      (idx_q)
  );

  scanseq_out u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (conv_trig),
    .entry      (cur_entry),
    .scan_en    (scan_en),
    .multi_en   (multi_en),
    .at_first   (idx_q == '0),
    .sel_valid  (sel_valid),
    .sel_chan   (sel_chan),
    .sel_gain   (sel_gain),
    .scan_start (scan_start),
    .scan_end   (scan_end)
  );
endmodule

// File: tb/test_scan_list_seq.sv
module test_scan_list_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_wr = 1'b0;
  logic [3:0]  idx_data = '0;
  logic        ent_wr = 1'b0;
  logic [15:0] ent_data = '0;
  logic        scan_en = 1'b0;
  logic        multi_en = 1'b0;
  logic        conv_trig = 1'b0;
  logic        sel_valid, scan_start, scan_end;
  logic [3:0]  sel_chan;
  logic [1:0]  sel_gain;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  scan_list_seq i_scan_list_seq (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_data(idx_data),
    .ent_wr(ent_wr), .ent_data(ent_data), .scan_en(scan_en),
    .multi_en(multi_en), .conv_trig(conv_trig), .sel_valid(sel_valid),
    .sel_chan(sel_chan), .sel_gain(sel_gain), .scan_start(scan_start),
    .scan_end(scan_end)
  );

  // packed {scan_start, scan_end, gain[1:0], chan[3:0]} for a three-entry walk
  localparam logic [7:0] WALK [7] = '{8'h93, 8'h29, 8'h7E, 8'h93, 8'h29, 8'h7E, 8'h93};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_idx(input logic [3:0] v);
    @(negedge clk); idx_wr = 1'b1; idx_data = v;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic put_ent(input logic [15:0] v);
    @(negedge clk); ent_wr = 1'b1; ent_data = v;
    @(negedge clk); ent_wr = 1'b0;
  endtask

  task automatic fire();
    @(negedge clk); conv_trig = 1'b1;
    @(negedge clk); conv_trig = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!sel_valid && !scan_start && !scan_end, "R1 flags", {sel_valid, scan_start, scan_end}, 0);
    chk(sel_chan == 0 && sel_gain == 0, "R1 sel", {sel_gain, sel_chan}, 0);
    fire();
    chk(sel_valid && sel_chan == 0 && sel_gain == 0, "R1 cleared slot0", {sel_valid, sel_gain, sel_chan}, 8'h40);

    // fill three entries; slot 1 has bit 5 and high bits set (R3)
    put_idx(4'd0); put_ent(16'h0043);
    put_idx(4'd1); put_ent(16'hF0A9);
    put_idx(4'd2); put_ent(16'h00DE);

    // R8 scan disabled: slot 2 repeated, no pulses
    for (int k = 0; k < 3; k++) begin
      fire();
      chk(sel_chan == 4'd14 && sel_gain == 2'd3, "R8 fixed entry", {sel_gain, sel_chan}, 8'h3E);
      chk(!scan_end && !scan_start, "R8 no pulses", {scan_start, scan_end}, 0);
    end

    // R2 index selects slot; R3 ignored bits
    put_idx(4'd1); fire();
    chk(sel_chan == 4'd9 && sel_gain == 2'd2, "R3 R2 slot1 fields", {sel_gain, sel_chan}, 8'h29);

    // table walk: R4 R5 R6 R9
    scan_en = 1'b1; multi_en = 1'b1;
    put_idx(4'd0);
    for (int k = 0; k < 7; k++) begin
      fire();
      chk(sel_valid, "R4 valid", sel_valid, 1);
      chk({scan_start, scan_end, sel_gain, sel_chan} == WALK[k], "R5 R6 R9 walk",
          {scan_start, scan_end, sel_gain, sel_chan}, WALK[k]);
    end
    @(negedge clk);
    chk(!sel_valid && !scan_end, "R4 single pulse", {sel_valid, scan_end}, 0);

    // R9 qualifier off
    multi_en = 1'b0;
    put_idx(4'd0); fire();
    chk(!scan_start && sel_chan == 4'd3, "R9 no start", {scan_start, sel_chan}, 3);
    multi_en = 1'b1;

    // R10 trigger with index write in the same cycle
    put_idx(4'd0);
    @(negedge clk); conv_trig = 1'b1; idx_wr = 1'b1; idx_data = 4'd2;
    @(negedge clk); conv_trig = 1'b0; idx_wr = 1'b0;
    chk(sel_chan == 4'd3, "R10 old index presented", sel_chan, 3);
    fire();
    chk(sel_chan == 4'd14 && scan_end, "R10 index loaded", {scan_end, sel_chan}, 8'h1E);

    // R7 no end flag anywhere: wrap 15 -> 0
    for (int i = 0; i < 16; i++) begin
      put_idx(4'(i)); put_ent(16'((i % 4) << 6) | 16'(i));
    end
    put_idx(4'd0);
    for (int k = 0; k < 17; k++) begin
      fire();
      chk(sel_chan == 4'(k % 16) && sel_gain == 2'(k % 4), "R7 wrap chan",
          {sel_gain, sel_chan}, ((k % 4) << 4) | (k % 16));
      chk(!scan_end, "R7 no end", scan_end, 0);
      chk(scan_start == (k % 16 == 0), "R7 R9 start", scan_start, (k % 16 == 0));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule